// File: doc/BRIEF.md
# Single-Slave Bus Arbiter with Idle Parking

This block decides which of up to sixteen bus masters owns one slave port of a multi-master interconnect. Masters raise level request lines. The slave side pulses an end-of-access strobe on the last cycle of each transfer. The arbiter then hands the port to the next master, chosen either round-robin or by programmable priority. While the port is idle, it parks the connection according to a selectable policy: disconnected, left with the most recent owner, or pointed at a programmed master.

A master that is already connected when it asks for the port starts its access on the next cycle, with no penalty. Any other master first receives one penalty cycle: its grant is visible but not yet usable. The penalty output marks that cycle, and the transfer output marks the cycles in which the connected master's access is running. Configuration inputs are sampled into registers every cycle, so a change is acted upon starting one clock after it is applied.

Top module: `slave_port_arbiter`

## Requirements
- R1: After reset (synchronous, active low), no master is connected: the grant vector is zero and the connected-valid, transfer and penalty outputs are low. The round-robin pointer holds master 0, so the first round-robin search begins at master 1. The configuration registers hold round-robin, no parking and fixed index 0.
- R2: The grant vector is zero or one-hot. It is non-zero exactly when the connected-valid output is high, and then its set bit is the connected-master index.
- R3: Suppose a request is seen while the port is idle and the requester is not the connected master. At the next edge the winner becomes connected and the penalty output is high for exactly one cycle. Transfer goes high on the following cycle, with the same master.
- R4: Suppose the connected master requests while the port is idle. Transfer goes high at the next edge with the same master and no penalty cycle, even if other masters request at the same time.
- R5: While transfer is high and end-of-access is low, the connected master and the transfer state do not change, whatever the requests do.
- R6: On a cycle with transfer and end-of-access both high, the requests seen in that cycle are arbitrated. If the winner is the current master, transfer stays high with no penalty. If the winner is a different master, the port moves to that master with one penalty cycle.
- R7: The arbitration type input selects round-robin when low and fixed priority when high. In round-robin, the search starts at the master after the last granted one and wraps at the master count.
- R8: In fixed-priority mode, each master has a 2-bit priority value; master i uses bits [2i+1:2i]. The highest value wins, and equal values go to the lowest master index.
- R9: The parking mode encoding 00 means no parking. At the end of an access with no request pending, the port is disconnected (connected-valid low). The next request from idle then pays the penalty cycle.
- R10: The parking mode encoding 01 means the last master stays connected. At the end of an access with no request pending, the same master stays connected for as long as the port is idle.
- R11: The parking mode encoding 10 means the port connects to the 4-bit fixed index whenever it is idle. The connection follows a rewrite of that index while idle. An index at or above the master count leaves the port disconnected.
- R12: The parking mode encoding 11 behaves as no parking. Every configuration input is registered, so the idle connection reflects a new setting two edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_MST | Request line per master, level |
| access_done_i | input | 1 | High on the final cycle of the running access |
| cfg_prio_mode_i | input | 1 | 0 round-robin, 1 fixed priority |
| cfg_prio_i | input | N_MST*PRIO_W | Packed per-master priority values |
| cfg_park_mode_i | input | 2 | Idle parking policy |
| cfg_park_sel_i | input | SEL_W | Fixed parking master index |
| gnt_o | output | N_MST | One-hot connection to a master |
| owner_o | output | $clog2(N_MST) | Index of the connected master |
| owner_vld_o | output | 1 | A master is connected |
| xfer_o | output | 1 | The connected master's access is running |
| penalty_o | output | 1 | Arbitration penalty cycle for a newly connected master |

## Verification
The bench targets several corner cases.

- **Round-robin wrap from the highest master back to master 0.** A design that did not wrap would hand the port to a master further from the pointer.
- **Priority ties.** These expose a comparison that lets the higher index win.
- **Back-to-back accesses by one master.** A design that forgets the current owner would insert a spurious penalty cycle.
- **A parked master requesting.** A design that always charges the penalty would show penalty for one cycle and delay transfer.
- **Parking in each mode, including the unused code, and a rewrite of the fixed index while idle.** A wrong policy decode leaves the port connected, disconnected or aimed at a stale master.

// File: rtl/sarb_pkg.sv
// Shared types for the single-slave arbiter.
// Assumes: parking policy is carried as a 2-bit code; code 2'b11 is unused.
package sarb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,   // no access running
        ST_WAIT = 2'b01,   // penalty cycle for a newly connected master
        ST_BUSY = 2'b10    // connected master's access in progress
    } sarb_state_e;

    localparam logic [1:0] PARK_NONE  = 2'b00;
    localparam logic [1:0] PARK_LAST  = 2'b01;
    localparam logic [1:0] PARK_FIXED = 2'b10;

endpackage

// File: rtl/sarb_cfg_reg.sv
// Configuration sampling registers.
// Captures every configuration input each cycle so arbitration and parking
// decisions use a stable copy. Assumes software drives these quasi-statically.
module sarb_cfg_reg #(
    parameter int N_MST  = 16,
    parameter int PRIO_W = 2,
    parameter int SEL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prio_mode_i,
    input  logic [N_MST*PRIO_W-1:0] prio_i,
    input  logic [1:0]              park_mode_i,
    input  logic [SEL_W-1:0]        park_sel_i,
    output logic                    prio_mode_q,
    output logic [N_MST*PRIO_W-1:0] prio_q,
    output logic [1:0]              park_mode_q,
    output logic [SEL_W-1:0]        park_sel_q
);
    import sarb_pkg::*;

    // Sample configuration; reset gives round-robin, no parking, index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_mode_q <= 1'b0;
            prio_q      <= '0;
            park_mode_q <= PARK_NONE;
            park_sel_q  <= '0;
        end else begin
            prio_mode_q <= prio_mode_i;
            prio_q      <= prio_i;
            park_mode_q <= park_mode_i;
            park_sel_q  <= park_sel_i;
        end
    end

endmodule

// File: rtl/sarb_pick.sv
// Winner selection among pending requests.
// Computes a round-robin winner (search from pointer+1, wrapping) and a
// fixed-priority winner (largest value, lowest index on ties), then selects
// one by mode. Purely combinational; assumes N_MST >= 2.
module sarb_pick #(
    parameter int N_MST  = 16,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = $clog2(N_MST)
) (
    input  logic [N_MST-1:0]        req_i,
    input  logic                    prio_mode_i,
    input  logic [N_MST*PRIO_W-1:0] prio_i,
    input  logic [IDX_W-1:0]        ptr_i,
    output logic [IDX_W-1:0]        win_idx_o,
    output logic                    win_vld_o
);
    logic [PRIO_W-1:0] prio_a [N_MST];
    logic [IDX_W-1:0]  rr_idx;
    logic [IDX_W-1:0]  fp_idx;
    logic              rr_found;
    logic              fp_found;
    logic [PRIO_W-1:0] fp_best;
    int                cand;

    // Unpack the flat priority vector into one field per master.
    for (genvar g = 0; g < N_MST; g++) begin : g_prio
        assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
    end

    // Round-robin search starting after the pointer, wrapping at N_MST.
    always_comb begin
        rr_idx   = '0;
        rr_found = 1'b0;
        cand     = 0;
        for (int off = 1; off <= N_MST; off++) begin
            cand = int'(ptr_i) + off;
            if (cand >= N_MST) cand = cand - N_MST;
            if (!rr_found && req_i[cand]) begin
                rr_found = 1'b1;
                rr_idx   = IDX_W'(cand);
            end
        end
    end

    // Fixed-priority search: strict compare keeps the lowest index on ties.
    always_comb begin
        fp_idx   = '0;
        fp_found = 1'b0;
        fp_best  = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (req_i[i] && (!fp_found || prio_a[i] > fp_best)) begin
                fp_found = 1'b1;
                fp_best  = prio_a[i];
                fp_idx   = IDX_W'(i);
            end
        end
    end

    // Select the winner for the configured arbitration type.
    always_comb begin
        win_vld_o = |req_i;
        win_idx_o = prio_mode_i ? fp_idx : rr_idx;
    end

endmodule

// File: rtl/sarb_park.sv
// Idle parking target.
// Given the policy code, the fixed index and the current connection, returns
// where the port should be connected when no request is pending.
module sarb_park #(
    parameter int N_MST = 16,
    parameter int SEL_W = 4,
    parameter int IDX_W = $clog2(N_MST)
) (
    input  logic [1:0]       mode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [IDX_W-1:0] cur_idx_i,
    input  logic             cur_vld_i,
    output logic [IDX_W-1:0] park_idx_o,
    output logic             park_vld_o
);
    import sarb_pkg::*;

    logic sel_ok;

    // Fixed index is usable only when it names an existing master.
    always_comb sel_ok = int'(sel_i) < N_MST;

    // Decode policy; the unused code falls back to no parking.
    always_comb begin
        park_idx_o = '0;
        park_vld_o = 1'b0;
        case (mode_i)
            PARK_LAST: begin
                park_idx_o = cur_idx_i;
                park_vld_o = cur_vld_i;
            end
            PARK_FIXED: begin
                if (sel_ok) begin
                    park_idx_o = IDX_W'(sel_i);
                    park_vld_o = 1'b1;
                end
            end
            default: begin
                park_idx_o = '0;
                park_vld_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/slave_port_arbiter.sv
// Arbiter for one slave port of a multi-master interconnect.
// Connects one master at a time, re-arbitrates only on end-of-access, charges
// one penalty cycle to a master that was not already connected and parks the
// idle port per policy. Assumes access_done_i pulses only while xfer_o is high.
module slave_port_arbiter #(
    parameter int N_MST  = 16,
    parameter int PRIO_W = 2,
    parameter int SEL_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_MST-1:0]           req_i,
    input  logic                       access_done_i,
    input  logic                       cfg_prio_mode_i,
    input  logic [N_MST*PRIO_W-1:0]    cfg_prio_i,
    input  logic [1:0]                 cfg_park_mode_i,
    input  logic [SEL_W-1:0]           cfg_park_sel_i,
    output logic [N_MST-1:0]           gnt_o,
    output logic [$clog2(N_MST)-1:0]   owner_o,
    output logic                       owner_vld_o,
    output logic                       xfer_o,
    output logic                       penalty_o
);
    import sarb_pkg::*;

    localparam int IDX_W = $clog2(N_MST);

    sarb_state_e            state_q, state_d;
    logic [IDX_W-1:0]       owner_q, owner_d;
    logic                   vld_q, vld_d;
    logic [IDX_W-1:0]       ptr_q, ptr_d;

    logic                    prio_mode_q;
    logic [N_MST*PRIO_W-1:0] prio_q;
    logic [1:0]              park_mode_q;
    logic [SEL_W-1:0]        park_sel_q;

    logic [IDX_W-1:0]       win_idx;
    logic                   win_vld;
    logic [IDX_W-1:0]       park_idx;
    logic                   park_vld;

    sarb_cfg_reg #(.N_MST(N_MST), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_mode_i (cfg_prio_mode_i),
        .prio_i      (cfg_prio_i),
        .park_mode_i (cfg_park_mode_i),
        .park_sel_i  (cfg_park_sel_i),
        .prio_mode_q (prio_mode_q),
        .prio_q      (prio_q),
        .park_mode_q (park_mode_q),
        .park_sel_q  (park_sel_q)
    );

    sarb_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .req_i       (req_i),
        .prio_mode_i (prio_mode_q),
        .prio_i      (prio_q),
        .ptr_i       (ptr_q),
        .win_idx_o   (win_idx),
        .win_vld_o   (win_vld)
    );

    sarb_park #(.N_MST(N_MST), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_park (
        .mode_i     (park_mode_q),
        .sel_i      (park_sel_q),
        .cur_idx_i  (owner_q),
        .cur_vld_i  (vld_q),
        .park_idx_o (park_idx),
        .park_vld_o (park_vld)
    );

    // Next connection, state and round-robin pointer.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        vld_d   = vld_q;
        ptr_d   = ptr_q;
        case (state_q)
            ST_IDLE: begin
                if (win_vld) begin
                    if (vld_q && req_i[owner_q]) begin
                        state_d = ST_BUSY;
                        ptr_d   = owner_q;
                    end else begin
                        state_d = ST_WAIT;
                        owner_d = win_idx;
                        vld_d   = 1'b1;
                        ptr_d   = win_idx;
                    end
                end else begin
                    owner_d = park_idx;
                    vld_d   = park_vld;
                end
            end
            ST_WAIT: state_d = ST_BUSY;
            ST_BUSY: begin
                if (access_done_i) begin
                    if (win_vld) begin
                        owner_d = win_idx;
                        vld_d   = 1'b1;
                        ptr_d   = win_idx;
                        state_d = (win_idx == owner_q) ? ST_BUSY : ST_WAIT;
                    end else begin
                        state_d = ST_IDLE;
                        owner_d = park_idx;
                        vld_d   = park_vld;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                vld_d   = 1'b0;
            end
        endcase
    end

    // State registers; reset leaves the port disconnected, pointer at 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            vld_q   <= 1'b0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            vld_q   <= vld_d;
            ptr_q   <= ptr_d;
        end
    end

    // Decode the connection into a one-hot grant.
    for (genvar g = 0; g < N_MST; g++) begin : g_gnt
        assign gnt_o[g] = vld_q && (owner_q == IDX_W'(g));
    end

    // Status outputs from the registered state.
    always_comb begin
        owner_o     = owner_q;
        owner_vld_o = vld_q;
        xfer_o      = (state_q == ST_BUSY);
        penalty_o   = (state_q == ST_WAIT);
    end

endmodule

// File: rtl/slave_port_arbiter_chk.sv
// Property checker for slave_port_arbiter, attached by bind.
// Observes ports plus the registered parking policy.
module slave_port_arbiter_chk #(
    parameter int N_MST = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_MST-1:0]         req_i,
    input logic                     access_done_i,
    input logic [1:0]               park_mode,
    input logic [N_MST-1:0]         gnt_o,
    input logic [$clog2(N_MST)-1:0] owner_o,
    input logic                     owner_vld_o,
    input logic                     xfer_o,
    input logic                     penalty_o
);
    // R2: grant is at most one-hot
    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2: grant present exactly when connected, on the connected index
    p_gnt_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld_o == (|gnt_o)) && (!owner_vld_o || gnt_o[owner_o]));

    // R3: penalty lasts one cycle and is followed by the transfer
    p_penalty_then_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        penalty_o |=> (xfer_o && !penalty_o && $stable(owner_o)));

    // R4: a parked master that requests starts at once
    p_parked_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_o && !penalty_o && owner_vld_o && req_i[owner_o])
        |=> (xfer_o && !penalty_o && $stable(owner_o)));

    // R5: no switch during a running access
    p_no_midswitch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && !access_done_i) |=> (xfer_o && $stable(owner_o) && owner_vld_o));

    // R6: penalty only for a master that was not connected before
    p_penalty_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(penalty_o) |-> (owner_vld_o && (!$past(owner_vld_o) || $past(owner_o) != owner_o)));

    // R9: no parking disconnects at end of access without requests
    p_park_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && access_done_i && req_i == '0 && park_mode == 2'b00) |=> !owner_vld_o);

    // R10: last-master parking keeps the connection
    p_park_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && access_done_i && req_i == '0 && park_mode == 2'b01)
        |=> (owner_vld_o && $stable(owner_o) && !xfer_o));

endmodule

bind slave_port_arbiter slave_port_arbiter_chk #(.N_MST(N_MST)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .access_done_i (access_done_i),
    .park_mode     (park_mode_q),
    .gnt_o         (gnt_o),
    .owner_o       (owner_o),
    .owner_vld_o   (owner_vld_o),
    .xfer_o        (xfer_o),
    .penalty_o     (penalty_o)
);

// File: tb/slave_port_arbiter_tb_top.sv
// Directed bench for slave_port_arbiter: one task per scenario.
module slave_port_arbiter_tb_top;

    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req;
    logic          done;
    logic          prio_mode;
    logic [2*N-1:0] prio;
    logic [1:0]    park_mode;
    logic [3:0]    park_sel;
    logic [N-1:0]  gnt;
    logic [3:0]    owner;
    logic          owner_vld;
    logic          xfer;
    logic          penalty;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    slave_port_arbiter #(.N_MST(N), .PRIO_W(2), .SEL_W(4)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req),
        .access_done_i   (done),
        .cfg_prio_mode_i (prio_mode),
        .cfg_prio_i      (prio),
        .cfg_park_mode_i (park_mode),
        .cfg_park_sel_i  (park_sel),
        .gnt_o           (gnt),
        .owner_o         (owner),
        .owner_vld_o     (owner_vld),
        .xfer_o          (xfer),
        .penalty_o       (penalty)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare the full connection state with the expected one.
    task automatic chk_conn(string tag, bit vld, int idx, bit x, bit pen);
        chk({tag, " vld"}, 32'(owner_vld), 32'(vld));
        if (vld) chk({tag, " owner"}, 32'(owner), 32'(idx));
        chk({tag, " gnt"}, 32'(gnt), vld ? (32'h1 << idx) : 32'h0);
        chk({tag, " xfer"}, 32'(xfer), 32'(x));
        chk({tag, " penalty"}, 32'(penalty), 32'(pen));
    endtask

    task automatic do_reset(bit pm, logic [1:0] mode, logic [3:0] sel);
        rst_n = 1'b0; req = '0; done = 1'b0;
        prio_mode = pm; park_mode = mode; park_sel = sel;
        step(); step();
        rst_n = 1'b1;
    endtask

    // Round-robin order, wrap, back-to-back, no parking.
    task automatic t_round_robin();
        prio = '0;
        do_reset(1'b0, 2'b00, 4'd0);
        step();
        chk_conn("R1 reset", 0, 0, 0, 0);
        req = 16'h0003; step();
        chk_conn("R1 R7 first search from master 1", 1, 1, 0, 1);
        req = 16'h000F; step();
        chk_conn("R3 xfer after penalty", 1, 1, 1, 0);
        for (int k = 0; k < 3; k++) begin
            step();
            chk_conn("R5 hold during access", 1, 1, 1, 0);
        end
        done = 1'b1; req = 16'h000D; step();
        done = 1'b0;
        chk_conn("R6 R7 next after 1 is 2", 1, 2, 0, 1);
        step();
        done = 1'b1; req = 16'h0009; step();
        done = 1'b0;
        chk_conn("R7 next after 2 is 3", 1, 3, 0, 1);
        step();
        done = 1'b1; req = 16'h0001; step();
        done = 1'b0;
        chk_conn("R7 wrap to 0", 1, 0, 0, 1);
        step();
        done = 1'b1; req = 16'h0001; step();
        chk_conn("R6 same master back-to-back", 1, 0, 1, 0);
        req = '0; step();
        done = 1'b0;
        chk_conn("R9 disconnect at end", 0, 0, 0, 0);
        step();
        chk_conn("R9 stays disconnected", 0, 0, 0, 0);
        req = 16'h0001; step();
        chk_conn("R9 idle start pays penalty", 1, 0, 0, 1);
        req = '0; step();
    endtask

    // Fixed-priority selection and ties.
    task automatic t_priority();
        prio = '0;
        prio[2*2 +: 2] = 2'd3;
        prio[5*2 +: 2] = 2'd3;
        prio[7*2 +: 2] = 2'd1;
        do_reset(1'b1, 2'b00, 4'd0);
        step();
        req = 16'h00A4; step();
        chk_conn("R8 tie goes to lowest index", 1, 2, 0, 1);
        step();
        done = 1'b1; req = 16'h00A0; step();
        done = 1'b0;
        chk_conn("R8 higher value wins", 1, 5, 0, 1);
        step();
        done = 1'b1; req = 16'h00C0; step();
        done = 1'b0;
        chk_conn("R8 R7 priority not rotation", 1, 7, 0, 1);
        req = '0; step();
        done = 1'b1; step();
        done = 1'b0;
    endtask

    // Last-master parking and zero-latency restart.
    task automatic t_park_last();
        prio = '0;
        do_reset(1'b0, 2'b01, 4'd0);
        step();
        req = 16'h0010; step();
        chk_conn("R3 master 4 penalty", 1, 4, 0, 1);
        step();
        done = 1'b1; req = '0; step();
        done = 1'b0;
        chk_conn("R10 stays with master 4", 1, 4, 0, 0);
        step(); step();
        chk_conn("R10 still parked", 1, 4, 0, 0);
        req = 16'h0050; step();
        chk_conn("R4 parked master no penalty", 1, 4, 1, 0);
        done = 1'b1; req = '0; step();
        done = 1'b0;
        chk_conn("R10 parked again", 1, 4, 0, 0);
        req = 16'h0040; step();
        chk_conn("R3 other master pays penalty", 1, 6, 0, 1);
        req = '0; step();
        done = 1'b1; step();
        done = 1'b0;
    endtask

    // Fixed parking, index rewrite, unused code.
    task automatic t_park_fixed();
        prio = '0;
        do_reset(1'b0, 2'b10, 4'd9);
        step(); step();
        chk_conn("R11 parks on 9", 1, 9, 0, 0);
        park_sel = 4'd11; step();
        chk_conn("R12 one edge later unchanged", 1, 9, 0, 0);
        step();
        chk_conn("R11 follows rewrite", 1, 11, 0, 0);
        req = 16'h0800; step();
        chk_conn("R4 fixed master no penalty", 1, 11, 1, 0);
        done = 1'b1; req = '0; step();
        done = 1'b0;
        chk_conn("R11 back to 11", 1, 11, 0, 0);
        req = 16'h0008; step();
        chk_conn("R11 other master penalty", 1, 3, 0, 1);
        req = '0; step();
        done = 1'b1; step();
        done = 1'b0;
        chk_conn("R11 returns to fixed", 1, 11, 0, 0);
        park_mode = 2'b11; step(); step();
        chk_conn("R12 unused code disconnects", 0, 0, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_round_robin();
        t_priority();
        t_park_last();
        t_park_fixed();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule